// File: doc/BRIEF.md
# Stream-Selective Translation Cache with Flush Sweep

This block is a small, fully associative cache of recent DMA page translations. It sits beside an address translator. Every entry records the stream that owns it, a virtual page number, a physical page number and an inclusive range of sub-page granules that may be reached through it. The translator asks it for a translation in one cycle. After a page walk, the translator fills it with the result.

Software drops cached translations through a small register port. It first writes a 16-bit mask with one bit per stream. It then writes the operation register with the flush trigger bit set. A sweep engine then visits one entry per clock and clears each valid entry whose stream bit is set in a copy of the mask taken at the trigger. Entries of other streams are kept. The busy bit of the operation register stays at one until the sweep is over, and software polls it. While the sweep runs, lookups are held off. Fills that belong to a stream being swept are thrown away.

Top module: `xlat_cache_flush`

## Requirements
- R1: After reset no lookup hits, the busy bit reads 0 and the mask register reads 0.
- R2: A write to address 0x04 stores wdata[15:0] as the stream mask, and reading address 0x04 returns it in bits [15:0] with zeros above. No other access changes the mask.
- R3: A write to address 0x00 with bit 20 set starts a sweep when none is running. Reading address 0x00 then returns busy in bit 2, and busy is high for exactly NUM_ENTRIES+1 cycles starting the cycle after the write. A write to 0x00 with bit 20 clear does not start a sweep.
- R4: When a sweep ends, every entry whose stream bit was set in the mask captured at the trigger misses, and entries of unmasked streams still hit.
- R5: A mask of 0xFFFF invalidates every entry.
- R6: A lookup hits only if a valid entry matches its stream ID, its virtual page number, and a sub-page index with start <= sub <= end. On a hit the entry's physical page number appears in the same cycle.
- R7: While busy is high, lk_ready is low and lk_hit stays low.
- R8: While busy is high, a fill whose stream bit is set in the captured mask is discarded, and a fill for any other stream is stored.
- R9: A fill whose stream ID and virtual page match an existing valid entry overwrites that entry. Otherwise the fill goes to the lowest-numbered invalid entry. If every entry is valid, it replaces the entry at a round-robin pointer that starts at entry 0 after reset and advances by one after each replacement.
- R10: A trigger written while a sweep runs is ignored, and the running sweep keeps its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_ready | output | 1 | Always 1 (accepts each access) |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| lk_valid | input | 1 | Lookup request |
| lk_sid | input | 4 | Lookup stream ID |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_sub | input | SUB_W | Lookup sub-page granule index |
| lk_ready | output | 1 | Low while a sweep runs |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page number of the hit |
| fl_valid | input | 1 | Fill request |
| fl_sid | input | 4 | Fill stream ID |
| fl_vpn | input | VPN_W | Fill virtual page number |
| fl_ppn | input | PPN_W | Fill physical page number |
| fl_start | input | SUB_W | First valid sub-page granule |
| fl_end | input | SUB_W | Last valid sub-page granule |

## Verification
The hardest case to reach is traffic that arrives in the middle of a sweep: a fill for a masked stream, a fill for an unmasked stream and a second trigger, all while the engine is partway through the entries. The bench writes the trigger, then drives these requests on chosen busy cycles that it counts with lk_ready. Afterwards it checks the sweep length and which keys still hit. Round-robin replacement is reached by first filling every entry with distinct keys from reset, so that the pointer position is known.

// File: rtl/xcf_pkg.sv
// Shared constants for the stream-selective translation cache.
// Assumes a byte-addressed register port with 8-bit addresses.
package xcf_pkg;
    localparam int          NUM_STREAMS = 16;
    localparam int          SID_W       = $clog2(NUM_STREAMS);
    localparam logic [7:0]  ADDR_OP     = 8'h00;
    localparam logic [7:0]  ADDR_MASK   = 8'h04;
    localparam int          BIT_FLUSH   = 20;
    localparam int          BIT_BUSY    = 2;
endpackage

// File: rtl/xcf_regs.sv
// Register front end: holds the stream mask, decodes the flush trigger,
// and returns the busy bit. Assumes each access completes in one cycle.
module xcf_regs
    import xcf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_valid,
    input  logic                   reg_write,
    input  logic [7:0]             reg_addr,
    input  logic [31:0]            reg_wdata,
    input  logic                   busy_i,
    output logic                   reg_ready,
    output logic [31:0]            reg_rdata,
    output logic [NUM_STREAMS-1:0] mask_o,
    output logic                   start_o
);
    logic [NUM_STREAMS-1:0] mask_q;
    logic                   mask_wr;

    assign reg_ready = 1'b1;
    assign mask_wr   = reg_valid && reg_write && (reg_addr == ADDR_MASK);
    assign start_o   = reg_valid && reg_write && (reg_addr == ADDR_OP) && reg_wdata[BIT_FLUSH];
    assign mask_o    = mask_q;

    // Store the stream mask on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= reg_wdata[NUM_STREAMS-1:0];
    end

    // Read mux for the two registers.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_OP)   reg_rdata[BIT_BUSY] = busy_i;
        if (reg_addr == ADDR_MASK) reg_rdata[NUM_STREAMS-1:0] = mask_q;
    end

    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q));
endmodule

// File: rtl/xcf_sweep.sv
// Flush sequencer: on a trigger it takes a copy of the mask and walks the
// entries one per clock, then spends one closing cycle. Later triggers
// are ignored until it is idle again.
module xcf_sweep
    import xcf_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [NUM_STREAMS-1:0] mask_i,
    output logic                   busy_o,
    output logic                   clr_en_o,
    output logic [IDX_W-1:0]       clr_idx_o,
    output logic [NUM_STREAMS-1:0] snap_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT);

    logic                   busy_q;
    logic [IDX_W-1:0]       idx_q;
    logic [NUM_STREAMS-1:0] snap_q;

    // Sweep state: start, step through the entries, close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            snap_q <= '0;
        end else if (!busy_q && start_i) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            snap_q <= mask_i;
        end else if (busy_q) begin
            if (idx_q == LAST) busy_q <= 1'b0;
            else               idx_q  <= idx_q + 1'b1;
        end
    end

    assign busy_o    = busy_q;
    assign clr_en_o  = busy_q && (idx_q != LAST);
    assign clr_idx_o = idx_q;
    assign snap_o    = snap_q;

    assert_sweep_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_q) |=> (busy_q && idx_q == '0));
    assert_sweep_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && idx_q == LAST) |=> !busy_q);
    assert_retrigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_i) |=> $stable(snap_q));
endmodule

// File: rtl/xcf_entry_array.sv
// Fully associative entry store. It compares lookups against every entry
// at once, picks the fill target (same key, then a free entry, then the
// round-robin entry) and applies sweep clears. When a fill and a clear
// land on the same entry, the fill wins.
module xcf_entry_array
    import xcf_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int VPN_W = 20,
    parameter int PPN_W = 24,
    parameter int SUB_W = 12,
    localparam int IDX_W = $clog2(N_ENT + 1),
    localparam int TGT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SID_W-1:0]       lk_sid,
    input  logic [VPN_W-1:0]       lk_vpn,
    input  logic [SUB_W-1:0]       lk_sub,
    output logic                   hit_o,
    output logic [PPN_W-1:0]       ppn_o,
    input  logic                   fill_en,
    input  logic [SID_W-1:0]       fl_sid,
    input  logic [VPN_W-1:0]       fl_vpn,
    input  logic [PPN_W-1:0]       fl_ppn,
    input  logic [SUB_W-1:0]       fl_start,
    input  logic [SUB_W-1:0]       fl_end,
    input  logic                   clr_en,
    input  logic [IDX_W-1:0]       clr_idx,
    input  logic [NUM_STREAMS-1:0] clr_mask,
    output logic [N_ENT-1:0]       vld_o
);
    logic [N_ENT-1:0] vld_q;
    logic [SID_W-1:0] sid_q [N_ENT];
    logic [VPN_W-1:0] vpn_q [N_ENT];
    logic [PPN_W-1:0] ppn_q [N_ENT];
    logic [SUB_W-1:0] st_q  [N_ENT];
    logic [SUB_W-1:0] en_q  [N_ENT];
    logic [N_ENT-1:0] hit_vec;
    logic [N_ENT-1:0] same_vec;
    logic [TGT_W-1:0] tgt;
    logic [TGT_W-1:0] rr_q;
    logic             use_rr;

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
        // Compare each entry against the lookup key and the fill key.
        always_comb begin
            hit_vec[gi]  = vld_q[gi] && (sid_q[gi] == lk_sid) && (vpn_q[gi] == lk_vpn)
                           && (lk_sub >= st_q[gi]) && (lk_sub <= en_q[gi]);
            same_vec[gi] = vld_q[gi] && (sid_q[gi] == fl_sid) && (vpn_q[gi] == fl_vpn);
        end

        // Entry storage: a sweep clear first, then a fill on top of it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[gi] <= 1'b0;
                sid_q[gi] <= '0;
                vpn_q[gi] <= '0;
                ppn_q[gi] <= '0;
                st_q[gi]  <= '0;
                en_q[gi]  <= '0;
            end else begin
                if (clr_en && clr_idx == IDX_W'(gi) && clr_mask[sid_q[gi]])
                    vld_q[gi] <= 1'b0;
                if (fill_en && tgt == TGT_W'(gi)) begin
                    vld_q[gi] <= 1'b1;
                    sid_q[gi] <= fl_sid;
                    vpn_q[gi] <= fl_vpn;
                    ppn_q[gi] <= fl_ppn;
                    st_q[gi]  <= fl_start;
                    en_q[gi]  <= fl_end;
                end
            end
        end
    end

    // OR together the physical page numbers of the hitting entries.
    always_comb begin
        ppn_o = '0;
        for (int i = 0; i < N_ENT; i++)
            if (hit_vec[i]) ppn_o = ppn_o | ppn_q[i];
    end
    assign hit_o = |hit_vec;
    assign vld_o = vld_q;

    // Choose the fill target: same key, else first free, else round-robin.
    always_comb begin
        logic found;
        found  = 1'b0;
        tgt    = rr_q;
        for (int i = 0; i < N_ENT; i++)
            if (!found && same_vec[i]) begin tgt = TGT_W'(i); found = 1'b1; end
        for (int i = 0; i < N_ENT; i++)
            if (!found && !vld_q[i]) begin tgt = TGT_W'(i); found = 1'b1; end
        use_rr = !found;
    end

    // Advance the replacement pointer after each replacement.
    always_ff @(posedge clk) begin
        if (!rst_n) rr_q <= '0;
        else if (fill_en && use_rr)
            rr_q <= (rr_q == TGT_W'(N_ENT - 1)) ? '0 : rr_q + 1'b1;
    end

    assert_single_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    assert_unique_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(same_vec));
endmodule

// File: rtl/xlat_cache_flush.sv
// Top level: register front end, sweep sequencer and entry array. It
// holds off lookups while a sweep runs and drops fills for swept streams.
module xlat_cache_flush
    import xcf_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int VPN_W = 20,
    parameter int PPN_W = 24,
    parameter int SUB_W = 12,
    localparam int IDX_W = $clog2(N_ENT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_valid,
    input  logic             reg_write,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic             reg_ready,
    output logic [31:0]      reg_rdata,
    input  logic             lk_valid,
    input  logic [3:0]       lk_sid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [SUB_W-1:0] lk_sub,
    output logic             lk_ready,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fl_valid,
    input  logic [3:0]       fl_sid,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [PPN_W-1:0] fl_ppn,
    input  logic [SUB_W-1:0] fl_start,
    input  logic [SUB_W-1:0] fl_end
);
    logic                   busy;
    logic                   start;
    logic [NUM_STREAMS-1:0] mask;
    logic [NUM_STREAMS-1:0] snap;
    logic                   clr_en;
    logic [IDX_W-1:0]       clr_idx;
    logic                   arr_hit;
    logic                   fill_en;
    logic [N_ENT-1:0]       vld;

    xcf_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy_i(busy),
        .reg_ready(reg_ready), .reg_rdata(reg_rdata), .mask_o(mask), .start_o(start)
    );

    xcf_sweep #(.N_ENT(N_ENT)) u_sweep (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mask_i(mask), .busy_o(busy),
        .clr_en_o(clr_en), .clr_idx_o(clr_idx), .snap_o(snap)
    );

    // Drop a fill that belongs to a stream being swept.
    assign fill_en = fl_valid && !(busy && snap[fl_sid]);

    xcf_entry_array #(.N_ENT(N_ENT), .VPN_W(VPN_W), .PPN_W(PPN_W), .SUB_W(SUB_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .lk_sid(lk_sid), .lk_vpn(lk_vpn), .lk_sub(lk_sub),
        .hit_o(arr_hit), .ppn_o(lk_ppn), .fill_en(fill_en), .fl_sid(fl_sid),
        .fl_vpn(fl_vpn), .fl_ppn(fl_ppn), .fl_start(fl_start), .fl_end(fl_end),
        .clr_en(clr_en), .clr_idx(clr_idx), .clr_mask(snap), .vld_o(vld)
    );

    // Hold off lookups while a sweep runs.
    assign lk_ready = !busy;
    assign lk_hit   = lk_valid && !busy && arr_hit;

    assert_drop_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fl_valid && snap[fl_sid]) |=> ($countones(vld) <= $past($countones(vld))));
    assert_busy_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: tb/xlat_cache_flush_tb_top.sv
// Directed bench for the stream-selective translation cache.
module xlat_cache_flush_tb_top;
    localparam int NE = 8;
    localparam int VW = 20;
    localparam int PW = 24;
    localparam int SW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_valid = 1'b0, reg_write = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_ready;
    logic [31:0]   reg_rdata;
    logic          lk_valid = 1'b0;
    logic [3:0]    lk_sid = '0;
    logic [VW-1:0] lk_vpn = '0;
    logic [SW-1:0] lk_sub = '0;
    logic          lk_ready, lk_hit;
    logic [PW-1:0] lk_ppn;
    logic          fl_valid = 1'b0;
    logic [3:0]    fl_sid = '0;
    logic [VW-1:0] fl_vpn = '0;
    logic [PW-1:0] fl_ppn = '0;
    logic [SW-1:0] fl_start = '0, fl_end = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    xlat_cache_flush #(.N_ENT(NE), .VPN_W(VW), .PPN_W(PW), .SUB_W(SW)) dut_i (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_valid = 1'b0;
    endtask

    task automatic fill(input logic [3:0] s, input logic [VW-1:0] v, input logic [PW-1:0] p,
                        input logic [SW-1:0] st, input logic [SW-1:0] en);
        @(negedge clk);
        fl_valid = 1'b1; fl_sid = s; fl_vpn = v; fl_ppn = p; fl_start = st; fl_end = en;
        @(negedge clk);
        fl_valid = 1'b0;
    endtask

    task automatic lookup(input logic [3:0] s, input logic [VW-1:0] v, input logic [SW-1:0] sb,
                          output logic h, output logic [PW-1:0] p);
        @(negedge clk);
        lk_valid = 1'b1; lk_sid = s; lk_vpn = v; lk_sub = sb;
        #1 h = lk_hit; p = lk_ppn;
        lk_valid = 1'b0;
    endtask

    // Start a flush and count busy cycles through lk_ready. Optionally
    // retrigger on busy cycle 3 and probe a lookup on busy cycle 2.
    task automatic flush(input logic [15:0] m, input bit retrig, output int cyc);
        logic [31:0] rd;
        reg_wr(8'h04, {16'h0, m});
        reg_wr(8'h00, 32'h0010_0000);
        reg_valid = 1'b0;
        reg_addr = 8'h00;
        #1 rd = reg_rdata;
        check(rd[2] == 1'b1, "R3 busy bit set", rd[2], 1);
        cyc = 0;
        while (!lk_ready && cyc < 100) begin
            cyc++;
            if (cyc == 2) begin
                lk_valid = 1'b1; lk_sid = 4'd3; lk_vpn = 20'h00A; lk_sub = 12'd0;
                #1 check(!lk_hit && !lk_ready, "R7 lookup stalled while busy", lk_hit, 0);
                lk_valid = 1'b0;
            end
            if (retrig && cyc == 3) begin
                reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h0010_0000;
            end else begin
                reg_valid = 1'b0; reg_write = 1'b0;
            end
            @(negedge clk);
            #1;
        end
        reg_valid = 1'b0; reg_write = 1'b0; reg_addr = 8'h00;
        #1 rd = reg_rdata;
        check(rd[2] == 1'b0, "R3 busy bit clear after sweep", rd[2], 0);
    endtask

    task automatic t_reset();
        logic [31:0] d; logic h; logic [PW-1:0] p;
        do_reset();
        reg_rd(8'h00, d); check(d == 0, "R1 op reg after reset", d, 0);
        reg_rd(8'h04, d); check(d == 0, "R1 mask after reset", d, 0);
        lookup(4'd0, 20'h0, 12'd0, h, p); check(!h, "R1 no hit after reset", h, 0);
    endtask

    task automatic t_mask_rw();
        logic [31:0] d;
        reg_wr(8'h04, 32'hFFFF_A5C3);
        reg_rd(8'h04, d); check(d == 32'h0000_A5C3, "R2 mask readback", d, 32'hA5C3);
        reg_wr(8'h08, 32'h0000_1111);
        reg_wr(8'h00, 32'h0000_0004);
        reg_rd(8'h04, d); check(d == 32'h0000_A5C3, "R2 mask unchanged by other writes", d, 32'hA5C3);
        check(lk_ready == 1'b1, "R3 op write without trigger starts nothing", lk_ready, 1);
    endtask

    task automatic t_hit_rules();
        logic h; logic [PW-1:0] p;
        fill(4'd4, 20'h033, 24'h000123, 12'd10, 12'd20);
        lookup(4'd4, 20'h033, 12'd10, h, p);
        check(h && p == 24'h123, "R6 hit at start bound", {h, p}, {1'b1, 24'h123});
        lookup(4'd4, 20'h033, 12'd20, h, p); check(h, "R6 hit at end bound", h, 1);
        lookup(4'd4, 20'h033, 12'd9, h, p);  check(!h, "R6 miss below start", h, 0);
        lookup(4'd4, 20'h033, 12'd21, h, p); check(!h, "R6 miss above end", h, 0);
        lookup(4'd5, 20'h033, 12'd15, h, p); check(!h, "R6 miss other stream", h, 0);
        lookup(4'd4, 20'h034, 12'd15, h, p); check(!h, "R6 miss other page", h, 0);
    endtask

    task automatic t_selective();
        logic h; logic [PW-1:0] p; int c;
        do_reset();
        fill(4'd3, 20'h00A, 24'h0000A0, 12'd0, 12'hFFF);
        fill(4'd5, 20'h00B, 24'h0000B0, 12'd0, 12'hFFF);
        fill(4'd9, 20'h00C, 24'h0000C0, 12'd0, 12'hFFF);
        flush(16'h0220, 1'b0, c);
        check(c == NE + 1, "R3 busy length", c, NE + 1);
        lookup(4'd5, 20'h00B, 12'd0, h, p); check(!h, "R4 masked stream dropped", h, 0);
        lookup(4'd9, 20'h00C, 12'd0, h, p); check(!h, "R4 masked stream 9 dropped", h, 0);
        lookup(4'd3, 20'h00A, 12'd0, h, p);
        check(h && p == 24'hA0, "R4 unmasked stream kept", {h, p}, {1'b1, 24'hA0});
    endtask

    task automatic t_retrigger();
        int c;
        flush(16'h0001, 1'b1, c);
        check(c == NE + 1, "R10 retrigger ignored", c, NE + 1);
        @(negedge clk);
        check(lk_ready == 1'b1, "R10 no second sweep", lk_ready, 1);
    endtask

    task automatic t_flush_all();
        logic h; logic [PW-1:0] p; int c;
        fill(4'd0, 20'h100, 24'h1, 12'd0, 12'hFFF);
        fill(4'd15, 20'h101, 24'h2, 12'd0, 12'hFFF);
        flush(16'hFFFF, 1'b0, c);
        lookup(4'd0, 20'h100, 12'd0, h, p);  check(!h, "R5 stream 0 cleared", h, 0);
        lookup(4'd15, 20'h101, 12'd0, h, p); check(!h, "R5 stream 15 cleared", h, 0);
        lookup(4'd3, 20'h00A, 12'd0, h, p);  check(!h, "R5 stream 3 cleared", h, 0);
    endtask

    task automatic t_fill_during();
        logic h; logic [PW-1:0] p;
        do_reset();
        fill(4'd3, 20'h00A, 24'h0000A0, 12'd0, 12'hFFF);
        reg_wr(8'h04, 32'h0000_0020);
        reg_wr(8'h00, 32'h0010_0000);
        fl_valid = 1'b1; fl_sid = 4'd5; fl_vpn = 20'h200; fl_ppn = 24'h55; fl_start = 0; fl_end = 12'hFFF;
        @(negedge clk);
        fl_sid = 4'd7; fl_vpn = 20'h300; fl_ppn = 24'h77;
        @(negedge clk);
        fl_valid = 1'b0;
        while (!lk_ready) @(negedge clk);
        lookup(4'd5, 20'h200, 12'd0, h, p); check(!h, "R8 masked fill discarded", h, 0);
        lookup(4'd7, 20'h300, 12'd0, h, p);
        check(h && p == 24'h77, "R8 unmasked fill stored", {h, p}, {1'b1, 24'h77});
        lookup(4'd3, 20'h00A, 12'd0, h, p); check(h, "R8 other entry survives", h, 1);
    endtask

    task automatic t_replace();
        logic h; logic [PW-1:0] p;
        do_reset();
        fill(4'd2, 20'h010, 24'hAAA, 12'd0, 12'hFFF);
        fill(4'd2, 20'h010, 24'hBBB, 12'd0, 12'hFFF);
        lookup(4'd2, 20'h010, 12'd0, h, p);
        check(h && p == 24'hBBB, "R9 same key overwritten", {h, p}, {1'b1, 24'hBBB});
        for (int i = 1; i < NE; i++) fill(4'd2, VW'(20'h010 + i), PW'(i), 12'd0, 12'hFFF);
        lookup(4'd2, 20'h010, 12'd0, h, p); check(h, "R9 first entry kept before full", h, 1);
        fill(4'd2, 20'h020, 24'h20, 12'd0, 12'hFFF);
        lookup(4'd2, 20'h010, 12'd0, h, p); check(!h, "R9 round-robin replaced entry 0", h, 0);
        lookup(4'd2, 20'h020, 12'd0, h, p); check(h, "R9 new entry present", h, 1);
        fill(4'd2, 20'h021, 24'h21, 12'd0, 12'hFFF);
        lookup(4'd2, 20'h011, 12'd0, h, p); check(!h, "R9 pointer advanced to entry 1", h, 0);
        lookup(4'd2, 20'h012, 12'd0, h, p); check(h, "R9 entry 2 untouched", h, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_mask_rw();
                t_hit_rules();
                t_selective();
                t_retrigger();
                t_flush_all();
                t_fill_during();
                t_replace();
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule